// File: doc/BRIEF.md
# Exception Entry and Priority Controller

This controller sits beside a processor's execution pipeline and chooses which exception, if any, is taken at the next instruction boundary. Seven request sources feed it: reset, undefined instruction, software call, instruction abort, data abort, normal interrupt and fast interrupt. A request that arrives between boundaries is latched as pending. When the boundary strobe is high, the controller takes the highest-priority pending request that the current status word does not mask. In the following cycle it raises a one-cycle entry pulse. The pulse carries the rewritten status word, the old status word to keep as saved status, the link value and the vector address.

The controller also holds one saved-status register for each exception mode. A return command looks up the register of the mode that the current status word names. One cycle later, the controller emits the stored word so the pipeline can restore it while it writes the program counter.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, no request is pending, and `entry_o`, `ret_o` and all data outputs are zero. Data outputs also read zero in any cycle without a pulse.
- R2: An exception is taken only in a cycle where `boundary_i` is high. A request raised while the strobe is low stays pending until a later boundary. `entry_o` is high for exactly the one cycle after the clock edge that takes the exception.
- R3: Priority, highest first, is: reset, data abort, fast interrupt, normal interrupt, instruction abort, undefined, software call. A request that loses stays pending and is taken at a later boundary.
- R4: `vector_o` is `VEC_BASE` plus an offset: 0x00 for reset, 0x04 for undefined, 0x08 for software call, 0x0C for instruction abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt. Offset 0x14 is never produced.
- R5: Bits 4:0 of `new_status_o` carry the target mode. The codes are: supervisor 5'h13 (reset, software call), abort 5'h17 (both aborts), undefined 5'h1B, normal interrupt 5'h12 and fast interrupt 5'h11. Codes 5'h10 and 5'h1F have no saved-status register.
- R6: Status bit 7 set blocks the normal interrupt, and status bit 6 set blocks the fast interrupt. A blocked request stays pending. Reset is taken whatever the masks hold.
- R7: Every entry sets bit 7 of `new_status_o`. Fast interrupt and reset entries also set bit 6. Other entries copy bit 6 from the old status.
- R8: Bits 31:8 and bit 5 of `new_status_o` equal the old status word, so the N, Z, C and V flags in bits 31:28 pass through unchanged.
- R9: With the entry pulse, `saved_status_o` equals `status_i` and `link_o` equals `pc_i` as they were in the taking cycle. The saved word is also stored in the target mode's saved-status register.
- R10: `ret_i` in a cycle whose status mode has a saved-status register raises `ret_o` one cycle later. `ret_status_o` then holds the word saved at the latest entry into that mode.
- R11: `ret_i` is ignored, with `ret_o` staying low, in a mode with no saved-status register and in any cycle that takes an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_reset_i | input | 1 | Reset exception request |
| req_undef_i | input | 1 | Undefined instruction request |
| req_swi_i | input | 1 | Software call request |
| req_iabt_i | input | 1 | Instruction abort request |
| req_dabt_i | input | 1 | Data abort request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_fiq_i | input | 1 | Fast interrupt request |
| boundary_i | input | 1 | Instruction boundary strobe |
| status_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| ret_i | input | 1 | Exception return command |
| entry_o | output | 1 | Entry pulse |
| new_status_o | output | 32 | Status word after entry |
| saved_status_o | output | 32 | Old status word to save |
| link_o | output | 32 | Link value |
| vector_o | output | 32 | Vector address |
| ret_o | output | 1 | Return pulse |
| ret_status_o | output | 32 | Status word to restore |

## Verification
Each result registers once. The entry pulse and its four data words are therefore due one cycle after the boundary edge that takes the request, and the return pulse is due one cycle after the edge that samples `ret_i`. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge, so each check reads exactly the cycle that the stimulus produced. Steps with the strobe low or the sources masked are checked at that same point for the absence of a pulse. The next strobe then shows that the held request survived.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int WORD  = 32;
  localparam int NSRC  = 7;
  localparam int NBANK = 5;
  localparam int SW    = $clog2(NSRC);
  localparam int BW    = 3;

  // source index doubles as priority rank (0 = highest)
  localparam logic [SW-1:0] SRC_RST  = 3'd0;
  localparam logic [SW-1:0] SRC_DABT = 3'd1;
  localparam logic [SW-1:0] SRC_FIQ  = 3'd2;
  localparam logic [SW-1:0] SRC_IRQ  = 3'd3;
  localparam logic [SW-1:0] SRC_IABT = 3'd4;
  localparam logic [SW-1:0] SRC_UND  = 3'd5;
  localparam logic [SW-1:0] SRC_SWI  = 3'd6;

  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;

  localparam logic [BW-1:0] BANK_NONE = 3'd7;

  function automatic logic [4:0] mode_for(input logic [SW-1:0] s);
    case (s)
      SRC_RST, SRC_SWI:   return MODE_SVC;
      SRC_DABT, SRC_IABT: return MODE_ABT;
      SRC_UND:            return MODE_UND;
      SRC_IRQ:            return MODE_IRQ;
      default:            return MODE_FIQ;
    endcase
  endfunction

  function automatic logic [7:0] offset_for(input logic [SW-1:0] s);
    case (s)
      SRC_RST:  return 8'h00;
      SRC_UND:  return 8'h04;
      SRC_SWI:  return 8'h08;
      SRC_IABT: return 8'h0C;
      SRC_DABT: return 8'h10;
      SRC_IRQ:  return 8'h18;
      default:  return 8'h1C;
    endcase
  endfunction

  function automatic logic [BW-1:0] bank_for(input logic [4:0] m);
    case (m)
      MODE_SVC: return 3'd0;
      MODE_ABT: return 3'd1;
      MODE_UND: return 3'd2;
      MODE_IRQ: return 3'd3;
      MODE_FIQ: return 3'd4;
      default:  return BANK_NONE;
    endcase
  endfunction

  function automatic logic [WORD-1:0] entry_word(input logic [WORD-1:0] old,
                                                 input logic [SW-1:0] s);
    logic [WORD-1:0] w;
    w      = old;
    w[4:0] = mode_for(s);
    w[7]   = 1'b1;
    if (s == SRC_FIQ || s == SRC_RST) w[6] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/exc_pend.sv
module exc_pend #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] elig_i,
  input  logic         take_i,
  output logic [N-1:0] pick_o,
  output logic         any_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] live;
  logic [N-1:0] cand;

  assign live  = pend_q | req_i;
  assign cand  = live & elig_i;
  assign any_o = |cand;

  always_comb begin
    pick_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick_o    = '0;
        pick_o[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= live & ~(take_i ? pick_o : '0);
  end
endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
  parameter int NB = 5,
  parameter int W  = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] bank_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) bank_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g)) bank_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NB; i++)
      if (rd_idx_i == IW'(i)) rd_data_o = bank_q[i];
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_reset_i,
  input  logic            req_undef_i,
  input  logic            req_swi_i,
  input  logic            req_iabt_i,
  input  logic            req_dabt_i,
  input  logic            req_irq_i,
  input  logic            req_fiq_i,
  input  logic            boundary_i,
  input  logic [WORD-1:0] status_i,
  input  logic [WORD-1:0] pc_i,
  input  logic            ret_i,
  output logic            entry_o,
  output logic [WORD-1:0] new_status_o,
  output logic [WORD-1:0] saved_status_o,
  output logic [WORD-1:0] link_o,
  output logic [WORD-1:0] vector_o,
  output logic            ret_o,
  output logic [WORD-1:0] ret_status_o
);
  logic [NSRC-1:0] req_w;
  logic [NSRC-1:0] elig_w;
  logic [NSRC-1:0] pick_w;
  logic            any_w;
  logic            take_w;
  logic [SW-1:0]   sel_w;
  logic [BW-1:0]   wr_bank_w;
  logic [BW-1:0]   ret_bank_w;
  logic            ret_ok_w;
  logic [WORD-1:0] bank_rd_w;

  always_comb begin
    req_w           = '0;
    req_w[SRC_RST]  = req_reset_i;
    req_w[SRC_DABT] = req_dabt_i;
    req_w[SRC_FIQ]  = req_fiq_i;
    req_w[SRC_IRQ]  = req_irq_i;
    req_w[SRC_IABT] = req_iabt_i;
    req_w[SRC_UND]  = req_undef_i;
    req_w[SRC_SWI]  = req_swi_i;
    elig_w          = '1;
    elig_w[SRC_FIQ] = ~status_i[6];
    elig_w[SRC_IRQ] = ~status_i[7];
  end

  exc_pend #(.N(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_w),
    .elig_i (elig_w),
    .take_i (take_w),
    .pick_o (pick_w),
    .any_o  (any_w)
  );

  assign take_w = boundary_i & any_w;

  always_comb begin
    sel_w = '0;
    for (int i = 0; i < NSRC; i++)
      if (pick_w[i]) sel_w = SW'(i);
  end

  assign wr_bank_w  = bank_for(mode_for(sel_w));
  assign ret_bank_w = bank_for(status_i[4:0]);
  assign ret_ok_w   = ret_i & ~take_w & (ret_bank_w != BANK_NONE);

  exc_bank #(.NB(NBANK), .W(WORD), .IW(BW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (take_w),
    .wr_idx_i  (wr_bank_w),
    .wr_data_i (status_i),
    .rd_idx_i  (ret_bank_w),
    .rd_data_o (bank_rd_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !take_w) begin
      entry_o        <= 1'b0;
      new_status_o   <= '0;
      saved_status_o <= '0;
      link_o         <= '0;
      vector_o       <= '0;
    end else begin
      entry_o        <= 1'b1;
      new_status_o   <= entry_word(status_i, sel_w);
      saved_status_o <= status_i;
      link_o         <= pc_i;
      vector_o       <= VEC_BASE + {24'h0, offset_for(sel_w)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ret_ok_w) begin
      ret_o        <= 1'b0;
      ret_status_o <= '0;
    end else begin
      ret_o        <= 1'b1;
      ret_status_o <= bank_rd_w;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary_i,
  input logic [31:0] status_i,
  input logic [31:0] pc_i,
  input logic        entry_o,
  input logic [31:0] new_status_o,
  input logic [31:0] saved_status_o,
  input logic [31:0] link_o,
  input logic [31:0] vector_o,
  input logic        ret_o,
  input logic [6:0]  pick_w,
  input logic        take_w
);
  // R2
  entry_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> $past(boundary_i));
  // R2
  take_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> entry_o);
  // R3
  single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_w));
  // R4
  no_hole_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> vector_o != VEC_BASE + 32'h14);
  // R6
  irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && vector_o == VEC_BASE + 32'h18) |-> !saved_status_o[7]);
  // R7
  fiq_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && vector_o == VEC_BASE + 32'h1C) |-> (new_status_o[7] && new_status_o[6]));
  // R7
  irq_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> new_status_o[7]);
  // R8
  kept_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (new_status_o[31:8] == saved_status_o[31:8] && new_status_o[5] == saved_status_o[5]));
  // R9
  link_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (link_o == $past(pc_i) && saved_status_o == $past(status_i)));
  // R11
  entry_ret_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_o && ret_o));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.VEC_BASE(VEC_BASE)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .boundary_i     (boundary_i),
  .status_i       (status_i),
  .pc_i           (pc_i),
  .entry_o        (entry_o),
  .new_status_o   (new_status_o),
  .saved_status_o (saved_status_o),
  .link_o         (link_o),
  .vector_o       (vector_o),
  .ret_o          (ret_o),
  .pick_w         (pick_w),
  .take_w         (take_w)
);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;
  // request bit positions used by the step task
  localparam int B_RST = 0, B_UND = 1, B_SWI = 2, B_IABT = 3, B_DABT = 4, B_IRQ = 5, B_FIQ = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] rq = '0;
  logic boundary = 1'b0, ret = 1'b0;
  logic [31:0] st = '0, pc = '0;
  logic entry_o, ret_o;
  logic [31:0] new_status_o, saved_status_o, link_o, vector_o, ret_status_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_reset_i(rq[B_RST]), .req_undef_i(rq[B_UND]), .req_swi_i(rq[B_SWI]),
    .req_iabt_i(rq[B_IABT]), .req_dabt_i(rq[B_DABT]), .req_irq_i(rq[B_IRQ]),
    .req_fiq_i(rq[B_FIQ]), .boundary_i(boundary), .status_i(st), .pc_i(pc),
    .ret_i(ret), .entry_o(entry_o), .new_status_o(new_status_o),
    .saved_status_o(saved_status_o), .link_o(link_o), .vector_o(vector_o),
    .ret_o(ret_o), .ret_status_o(ret_status_o)
  );

  function automatic logic [31:0] expect_word(logic [31:0] old, logic [4:0] m, bit f);
    return {old[31:8], 1'b1, old[6] | f, old[5], m};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [6:0] r, bit b, logic [31:0] s, logic [31:0] p, bit rt);
    @(negedge clk);
    rq = r; boundary = b; st = s; pc = p; ret = rt;
    @(posedge clk);
    #1;
    rq = '0; boundary = 1'b0; ret = 1'b0;
  endtask

  task automatic expect_entry(string tag, logic [31:0] vec, logic [31:0] old,
                              logic [4:0] m, bit f, logic [31:0] p);
    chk({tag, " entry"}, {31'h0, entry_o}, 32'h1);
    chk({tag, " vector"}, vector_o, vec);
    chk({tag, " new status"}, new_status_o, expect_word(old, m, f));
    chk({tag, " saved"}, saved_status_o, old);
    chk({tag, " link"}, link_o, p);
  endtask

  task automatic t_reset_state();
    chk("R1 entry idle", {31'h0, entry_o}, 32'h0);
    chk("R1 ret idle", {31'h0, ret_o}, 32'h0);
    chk("R1 vector zero", vector_o, 32'h0);
    chk("R1 status zero", new_status_o, 32'h0);
  endtask

  task automatic t_boundary_hold();
    step(7'b1 << B_UND, 1'b0, 32'h0000_0010, 32'h100, 1'b0);
    chk("R2 no entry without boundary", {31'h0, entry_o}, 32'h0);
    step('0, 1'b0, 32'h0000_0010, 32'h104, 1'b0);
    chk("R2 still held", {31'h0, entry_o}, 32'h0);
    step('0, 1'b1, 32'h0000_0010, 32'h108, 1'b0);
    expect_entry("R2 R4 R5 undefined", 32'h04, 32'h0000_0010, 5'h1B, 1'b0, 32'h108);
    step('0, 1'b1, 32'h0000_0010, 32'h10C, 1'b0);
    chk("R2 single pulse", {31'h0, entry_o}, 32'h0);
    chk("R1 idle data zero", link_o, 32'h0);
  endtask

  task automatic t_priority();
    step((7'b1 << B_DABT) | (7'b1 << B_IRQ) | (7'b1 << B_IABT), 1'b0, 32'h0000_0010, 32'h200, 1'b0);
    step('0, 1'b1, 32'h4000_0010, 32'h204, 1'b0);
    expect_entry("R3 dabt first", 32'h10, 32'h4000_0010, 5'h17, 1'b0, 32'h204);
    step('0, 1'b1, 32'h0000_0010, 32'h208, 1'b0);
    expect_entry("R3 irq second", 32'h18, 32'h0000_0010, 5'h12, 1'b0, 32'h208);
    step('0, 1'b1, 32'h0000_0010, 32'h20C, 1'b0);
    expect_entry("R3 iabt third", 32'h0C, 32'h0000_0010, 5'h17, 1'b0, 32'h20C);
    step('0, 1'b1, 32'h0000_0010, 32'h210, 1'b0);
    chk("R3 queue empty", {31'h0, entry_o}, 32'h0);
    step((7'b1 << B_SWI) | (7'b1 << B_UND), 1'b1, 32'h0000_0010, 32'h214, 1'b0);
    expect_entry("R3 undef over swi", 32'h04, 32'h0000_0010, 5'h1B, 1'b0, 32'h214);
    step('0, 1'b1, 32'h0000_0010, 32'h218, 1'b0);
    expect_entry("R3 R4 swi later", 32'h08, 32'h0000_0010, 5'h13, 1'b0, 32'h218);
  endtask

  task automatic t_masks();
    step((7'b1 << B_IRQ) | (7'b1 << B_FIQ), 1'b1, 32'h0000_00D3, 32'h300, 1'b0);
    chk("R6 both masked", {31'h0, entry_o}, 32'h0);
    step('0, 1'b1, 32'h0000_0053, 32'h304, 1'b0);
    expect_entry("R6 irq after unmask", 32'h18, 32'h0000_0053, 5'h12, 1'b0, 32'h304);
    step('0, 1'b1, 32'h0000_0092, 32'h308, 1'b0);
    expect_entry("R6 R7 fiq after unmask", 32'h1C, 32'h0000_0092, 5'h11, 1'b1, 32'h308);
    step(7'b1 << B_RST, 1'b1, 32'hF000_00D0, 32'h30C, 1'b0);
    expect_entry("R6 R7 reset ignores masks", 32'h00, 32'hF000_00D0, 5'h13, 1'b1, 32'h30C);
  endtask

  task automatic t_flags_and_return();
    step(7'b1 << B_SWI, 1'b1, 32'hA000_0030, 32'h1234, 1'b0);
    expect_entry("R8 R9 swi flags kept", 32'h08, 32'hA000_0030, 5'h13, 1'b0, 32'h1234);
    chk("R8 exact word", new_status_o, 32'hA000_00B3);
    step('0, 1'b0, 32'hA000_00B3, 32'h40, 1'b1);
    chk("R10 ret pulse", {31'h0, ret_o}, 32'h1);
    chk("R10 ret status", ret_status_o, 32'hA000_0030);
    chk("R10 no entry", {31'h0, entry_o}, 32'h0);
    step('0, 1'b0, 32'h0000_0010, 32'h44, 1'b1);
    chk("R11 user mode ignored", {31'h0, ret_o}, 32'h0);
    chk("R11 user mode data", ret_status_o, 32'h0);
    step(7'b1 << B_UND, 1'b1, 32'h5000_0093, 32'h48, 1'b1);
    chk("R11 entry wins", {31'h0, ret_o}, 32'h0);
    expect_entry("R11 R9 undef with ret", 32'h04, 32'h5000_0093, 5'h1B, 1'b0, 32'h48);
    step('0, 1'b0, 32'h5000_009B, 32'h4C, 1'b1);
    chk("R10 und bank", ret_status_o, 32'h5000_0093);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    t_boundary_hold();
    t_priority();
    t_masks();
    t_flags_and_return();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule